// File: doc/BRIEF.md
# Two-Wire Register Access Slave

This block lets an external bus master read and write a bank of 8-bit registers over a two-wire serial bus. SCL and SDA are brought into the system clock domain through a synchroniser, edge-detected, and decoded into START, STOP and bit-clock events. A small state machine then receives the device address byte, the register subaddress and data bytes, and reaches the register file through a one-cycle write strobe and a one-cycle read request.

A write transaction carries the device address with the direction bit clear, one subaddress byte that loads an internal register pointer, and then any number of data bytes. A read transaction carries only the device address with the direction bit set. Data then flows out of the register at the current pointer and continues until the master declines to acknowledge a byte. The pointer steps by one after every data byte in both directions and wraps at the top of the 8-bit space. Repeated START is not supported: any START simply restarts address reception.

The block never drives SDA high. It pulls the line low through an output-enable, which the surrounding pad logic turns into an open-drain driver. The register file that the block accesses is external, and its read data must be valid on the cycle after a read request.

Top module: `twl_reg_slave`

## Requirements
- R1: A high-to-low SDA change while SCL is high (START) aborts any transfer in progress and restarts address reception. A low-to-high SDA change while SCL is high (STOP) returns the block to idle, and bytes clocked after a STOP and before the next START get no acknowledge.
- R2: The first byte after START is taken MSB first. Bits [7:1] are the device address and bit 0 is the direction, with 1 meaning read. When bits [7:1] equal `dev_addr`, the block pulls SDA low in the acknowledge slot.
- R3: When the address does not match, the block gives no acknowledge, performs no register write, never asserts `sda_oe` and ignores the bus until the next START.
- R4: In a write transaction, the byte after the address byte loads the register pointer. That byte and every following data byte are acknowledged.
- R5: For each write data byte, `reg_we` is high for exactly one system clock after the byte's eighth bit is captured, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: The pointer increases by one after every data byte written or read, and wraps from 0xFF to 0x00.
- R7: A read transaction has no subaddress. Its first data byte comes from the register at the current pointer, shifted out MSB first. The data is requested with `reg_re` before the first bit is driven.
- R8: During a read, a master acknowledge (SDA low) makes the block send the next register. A not-acknowledge (SDA high) makes it release SDA and stop sending until the next START.
- R9: `sda_oe` changes only on the clock after a detected SCL falling edge, START or STOP, and never while SCL is high.
- R10: After reset, `sda_oe`, `reg_we` and `reg_re` are low and the pointer (`reg_addr`) is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dev_addr | input | 7 | Device address this slave answers to |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 8 | Register pointer presented to the register file |
| reg_wdata | output | 8 | Write data for the register file |
| reg_we | output | 1 | One-cycle register write strobe |
| reg_re | output | 1 | One-cycle register read request; data is expected the next cycle |
| reg_rdata | input | 8 | Register read data |

## Verification
The bench writes a burst across address 0xFF, so a pointer that saturates or fails to wrap stores to the wrong registers, and reading the burst back exposes it. It reads through the master acknowledge and not-acknowledge paths and then continues with a second read. A slave that keeps driving after the not-acknowledge would corrupt the line, and a pointer that fails to advance would return stale data. A foreign address is followed by data bytes, so a slave that acknowledges or writes there is caught by the acknowledge and strobe counts. A START in the middle of a data byte, and bytes sent after a STOP, show whether the block resynchronises correctly instead of finishing a stale byte.

// File: rtl/twl_pkg.sv
package twl_pkg;
    localparam int BYTE_W = 8;
    localparam int PTR_W  = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_SUB, ST_SUB_ACK,
        ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
    } twl_state_e;

    typedef struct packed {
        twl_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   rx;
        logic [BYTE_W-1:0]   tx;
        logic [PTR_W-1:0]    ptr;
        logic [BYTE_W-1:0]   wdata;
        logic                rw;
        logic                oe;
        logic                we;
        logic                re;
    } twl_regs_t;
endpackage

// File: rtl/twl_line_sync.sv
module twl_line_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[0] <= '1;
                    else        stg_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg_q[g] <= '1;
                    else        stg_q[g] <= stg_q[g-1];
                end
            end
        end
    endgenerate

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/twl_bus_events.sv
module twl_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_prev_q;
        scl_fall  = ~scl_s & scl_prev_q;
        bus_start = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
        bus_stop  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
    end
endmodule

// File: rtl/twl_reg_slave.sv
module twl_reg_slave
    import twl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [6:0]        dev_addr,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    output logic              reg_re,
    input  logic [BYTE_W-1:0] reg_rdata
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

    logic [1:0] sync_out;
    logic       scl_s, sda_s;
    logic       ev_rise, ev_fall, ev_start, ev_stop;
    twl_regs_t  r_d, r_q;

    twl_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .dout(sync_out)
    );
    assign scl_s = sync_out[1];
    assign sda_s = sync_out[0];

    twl_bus_events u_events (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(ev_rise), .scl_fall(ev_fall),
        .bus_start(ev_start), .bus_stop(ev_stop)
    );

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        r_d.re = 1'b0;
        if (r_q.we) r_d.ptr = r_q.ptr + 1'b1;

        if (ev_start) begin
            r_d.state = ST_ADDR;
            r_d.cnt   = '0;
            r_d.oe    = 1'b0;
        end else if (ev_stop) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_ADDR, ST_SUB, ST_WR: begin
                    if (ev_rise && r_q.cnt < FULL) begin
                        r_d.rx  = {r_q.rx[BYTE_W-2:0], sda_s};
                        r_d.cnt = r_q.cnt + 1'b1;
                        if (r_q.state == ST_WR && r_q.cnt == LAST_BIT) begin
                            r_d.we    = 1'b1;
                            r_d.wdata = {r_q.rx[BYTE_W-2:0], sda_s};
                        end
                    end else if (ev_fall && r_q.cnt == FULL) begin
                        if (r_q.state == ST_ADDR) begin
                            if (r_q.rx[BYTE_W-1:1] == dev_addr) begin
                                r_d.oe    = 1'b1;
                                r_d.rw    = r_q.rx[0];
                                r_d.re    = r_q.rx[0];
                                r_d.state = ST_ADDR_ACK;
                            end else begin
                                r_d.state = ST_IDLE;
                            end
                        end else if (r_q.state == ST_SUB) begin
                            r_d.ptr   = r_q.rx;
                            r_d.oe    = 1'b1;
                            r_d.state = ST_SUB_ACK;
                        end else begin
                            r_d.oe    = 1'b1;
                            r_d.state = ST_WR_ACK;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (ev_fall) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.tx    = reg_rdata;
                            r_d.oe    = ~reg_rdata[BYTE_W-1];
                            r_d.state = ST_RD;
                        end else begin
                            r_d.oe    = 1'b0;
                            r_d.state = ST_SUB;
                        end
                    end
                end
                ST_SUB_ACK, ST_WR_ACK: begin
                    if (ev_fall) begin
                        r_d.oe    = 1'b0;
                        r_d.cnt   = '0;
                        r_d.state = ST_WR;
                    end
                end
                ST_RD: begin
                    if (ev_rise && r_q.cnt < FULL) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (ev_fall) begin
                        if (r_q.cnt == FULL) begin
                            r_d.oe    = 1'b0;
                            r_d.ptr   = r_q.ptr + 1'b1;
                            r_d.state = ST_RD_ACK;
                        end else begin
                            r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                            r_d.oe = ~r_q.tx[BYTE_W-2];
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (ev_rise) begin
                        r_d.rx[0] = sda_s;
                        r_d.re    = ~sda_s;
                    end else if (ev_fall) begin
                        if (r_q.rx[0]) begin
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.tx    = reg_rdata;
                            r_d.oe    = ~reg_rdata[BYTE_W-1];
                            r_d.cnt   = '0;
                            r_d.state = ST_RD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = r_q.oe;
    assign reg_addr  = r_q.ptr;
    assign reg_wdata = r_q.wdata;
    assign reg_we    = r_q.we;
    assign reg_re    = r_q.re;

    // R9: the SDA driver only moves after a detected bus event
    a_r9_oe_after_event: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(ev_fall || ev_start || ev_stop));

    // R1: a START always leaves the line released
    a_r1_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> !sda_oe);

    // R5: write strobe lasts a single cycle
    a_r5_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R5: write and read requests never overlap
    a_r5_we_re_apart: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));

    // R6: pointer steps by one, wrapping, after each write
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_addr == PTR_W'($past(reg_addr) + 1'b1));
endmodule

// File: tb/tb_twl_reg_slave.sv
module tb_twl_reg_slave;
    localparam int T = 20;
    localparam logic [6:0] DEV = 7'h42;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe, reg_we, reg_re;
    logic [7:0] reg_addr, reg_wdata, reg_rdata;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    int we_cnt = 0;
    int we_long = 0;
    int oe_rises = 0;
    int oe_bad = 0;
    int oe_moves = 0;
    logic [7:0] log_addr [64];
    logic [7:0] log_data [64];
    logic [7:0] mem [256];
    logic prev_we = 1'b0;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    twl_reg_slave dut (
        .clk(clk), .rst_n(rst_n), .dev_addr(DEV),
        .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata)
    );

    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
        if (reg_re) reg_rdata <= mem[reg_addr];
    end

    always @(posedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                log_addr[we_cnt % 64] = reg_addr;
                log_data[we_cnt % 64] = reg_wdata;
                we_cnt++;
            end
            if (reg_we && prev_we) we_long++;
            if (sda_oe !== prev_oe) begin
                oe_moves++;
                if (scl_m) oe_bad++;
                if (sda_oe) oe_rises++;
            end
        end
        prev_we = reg_we;
        prev_oe = sda_oe;
    end

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_clks(T);
        scl_m = 1'b1; wait_clks(T);
        sda_m = 1'b0; wait_clks(T);
        scl_m = 1'b0; wait_clks(2);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_clks(T);
        scl_m = 1'b1; wait_clks(T);
        sda_m = 1'b1; wait_clks(T);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_clks(T);
            scl_m = 1'b1; wait_clks(T);
            scl_m = 1'b0; wait_clks(2);
        end
        sda_m = 1'b1; wait_clks(T);
        scl_m = 1'b1; wait_clks(T/2);
        ack = !sda_line;
        wait_clks(T/2);
        scl_m = 1'b0; wait_clks(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit m_ack);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wait_clks(T);
            scl_m = 1'b1; wait_clks(T/2);
            b[i] = sda_line;
            wait_clks(T/2);
            scl_m = 1'b0;
        end
        wait_clks(2);
        sda_m = m_ack ? 1'b0 : 1'b1;
        wait_clks(T);
        scl_m = 1'b1; wait_clks(T);
        scl_m = 1'b0; wait_clks(2);
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [7:0] sub);
        bit a;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(sub, a);
        bus_stop;
    endtask

    task automatic t_reset;
        chk(sda_oe == 1'b0, "R10", "sda_oe after reset", sda_oe, 0);
        chk(reg_we == 1'b0, "R10", "reg_we after reset", reg_we, 0);
        chk(reg_re == 1'b0, "R10", "reg_re after reset", reg_re, 0);
        chk(reg_addr == 8'h00, "R10", "pointer after reset", reg_addr, 0);
    endtask

    task automatic t_single_write;
        bit a;
        int base = we_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        chk(a, "R2", "address ack", a, 1);
        send_byte(8'h30, a);
        chk(a, "R4", "subaddress ack", a, 1);
        send_byte(8'h5A, a);
        chk(a, "R4", "data ack", a, 1);
        bus_stop;
        chk(we_cnt == base + 1, "R5", "write strobes", we_cnt - base, 1);
        chk(we_long == 0, "R5", "strobe longer than one clock", we_long, 0);
        chk(log_addr[base % 64] == 8'h30, "R5", "write address", log_addr[base % 64], 8'h30);
        chk(log_data[base % 64] == 8'h5A, "R5", "write data", log_data[base % 64], 8'h5A);
    endtask

    task automatic t_burst_wrap;
        bit a;
        int base = we_cnt;
        logic [7:0] exp_a [4] = '{8'hFE, 8'hFF, 8'h00, 8'h01};
        logic [7:0] exp_d [4] = '{8'h11, 8'h22, 8'h33, 8'hC4};
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'hFE, a);
        for (int i = 0; i < 4; i++) begin
            send_byte(exp_d[i], a);
            chk(a, "R4", "burst data ack", a, 1);
        end
        bus_stop;
        chk(we_cnt == base + 4, "R6", "burst strobes", we_cnt - base, 4);
        for (int i = 0; i < 4; i++) begin
            chk(log_addr[(base + i) % 64] == exp_a[i], "R6", "wrapped address",
                log_addr[(base + i) % 64], exp_a[i]);
            chk(log_data[(base + i) % 64] == exp_d[i], "R5", "burst data",
                log_data[(base + i) % 64], exp_d[i]);
        end
    endtask

    task automatic t_read_wrap;
        bit a;
        logic [7:0] b;
        logic [7:0] exp_d [3] = '{8'h11, 8'h22, 8'h33};
        set_ptr(8'hFE);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        chk(a, "R7", "read address ack", a, 1);
        for (int i = 0; i < 3; i++) begin
            recv_byte(b, i < 2);
            chk(b == exp_d[i], "R7", "read byte", b, exp_d[i]);
        end
        wait_clks(5);
        chk(sda_oe == 1'b0, "R8", "released after nack", sda_oe, 0);
        chk(sda_line == 1'b1, "R8", "line high after nack", sda_line, 1);
        bus_stop;
    endtask

    task automatic t_read_continue;
        bit a;
        logic [7:0] b;
        bus_start;
        send_byte({DEV, 1'b1}, a);
        recv_byte(b, 1'b0);
        chk(b == 8'hC4, "R7", "read resumes at pointer", b, 8'hC4);
        bus_stop;
    endtask

    task automatic t_mismatch;
        bit a;
        logic [7:0] b;
        int base_we = we_cnt;
        int base_oe = oe_rises;
        bus_start;
        send_byte({7'h21, 1'b0}, a);
        chk(!a, "R3", "foreign address ack", a, 0);
        send_byte(8'h30, a);
        chk(!a, "R3", "ignored subaddress ack", a, 0);
        send_byte(8'hEE, a);
        bus_stop;
        chk(we_cnt == base_we, "R3", "writes on foreign address", we_cnt - base_we, 0);
        chk(oe_rises == base_oe, "R3", "sda_oe on foreign address", oe_rises - base_oe, 0);
        set_ptr(8'h30);
        bus_start;
        send_byte({DEV, 1'b1}, a);
        recv_byte(b, 1'b0);
        bus_stop;
        chk(b == 8'h5A, "R3", "register untouched", b, 8'h5A);
    endtask

    task automatic t_abort_and_stop;
        bit a;
        int base = we_cnt;
        bus_start;
        send_byte({DEV, 1'b0}, a);
        send_byte(8'h40, a);
        for (int i = 0; i < 3; i++) begin
            sda_m = 1'b1; wait_clks(T);
            scl_m = 1'b1; wait_clks(T);
            scl_m = 1'b0; wait_clks(2);
        end
        bus_start;
        send_byte({DEV, 1'b0}, a);
        chk(a, "R1", "address ack after restart", a, 1);
        send_byte(8'h50, a);
        send_byte(8'h77, a);
        bus_stop;
        chk(we_cnt == base + 1, "R1", "writes after abort", we_cnt - base, 1);
        chk(log_addr[base % 64] == 8'h50, "R1", "restart address", log_addr[base % 64], 8'h50);
        chk(log_data[base % 64] == 8'h77, "R1", "restart data", log_data[base % 64], 8'h77);
        scl_m = 1'b0; wait_clks(T);
        send_byte({DEV, 1'b0}, a);
        chk(!a, "R1", "ack without START after STOP", a, 0);
        scl_m = 1'b1; wait_clks(T);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wait_clks(5);
        t_reset;
        rst_n = 1'b1;
        wait_clks(5);
        t_reset;
        t_single_write;
        t_burst_wrap;
        t_read_wrap;
        t_read_continue;
        t_mismatch;
        t_abort_and_stop;
        chk(oe_moves > 0, "R9", "sda_oe activity", oe_moves, 1);
        chk(oe_bad == 0, "R9", "sda_oe moved while SCL high", oe_bad, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule